// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers 32 interrupt request lines and drives one interrupt line to the processor. Software sets up the controller through a word-wide register port. Each source has a 2-bit trigger mode, which picks active-low level, active-high level, falling edge or rising edge. Each source also has a 3-bit priority level, where level 0 keeps the source out of arbitration. A global mask value sets a threshold, and a source must rise above it to compete.

Each cycle the controller picks the strongest pending source above the threshold. It registers that source's number and level in a current-status word, together with a flag that reads 1 when nothing is pending. The processor line is asserted in the same cycle that the status word shows a winner. An edge-mode source keeps its request in a sticky bit until software clears it. Software clears it by writing the source number to the clear register with the clear-enable bit set.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the enable bit, both mode registers, every level field and the mask read 0, and current-status reads 0x0001_0000.
- R2: Bit 0 of the control register (byte 0x00) gates the controller. While it is 0, current-status reads 0x0001_0000 and irq_out stays low one cycle later.
- R3: The 2-bit mode of source n sits in the register at 0x04 + 4·(n/16), at bits (n mod 16)·2. The encodings are 00 for active-low level, 01 for active-high level, 10 for falling edge and 11 for rising edge.
- R4: The level of source n sits in the register at 0x10 + 4·((n mod 16)/2), in the byte at bit (n/16)·16 + (n&1)·8. Only the low 3 bits of each byte are stored, and the other bits read as 0.
- R5: The mask is bits 2:0 at 0x40. A pending source competes only when its level is strictly greater than the mask, so level 0 never competes.
- R6: Among the competing sources, the highest level wins, and on a tie the lowest source number wins.
- R7: A detected edge sets a sticky pending bit that stays set after the input returns. A write to 0x60 with bit 8 set clears the sticky bit of the source numbered in bits 4:0. The same write with bit 8 clear changes nothing. If a new edge arrives in the same cycle as the clear, the bit stays set.
- R8: Current-status at 0xA0 has bit 16 = 1 when there is no winner, bits 10:8 = the winner's level and bits 4:0 = the winner's number. All other bits are 0.
- R9: irq_out is high exactly when current-status bit 16 is 0.
- R10: Reading 0x80 returns the per-source pending vector, made of live level matches and sticky edge bits.
- R11: A level request shows in current-status after one rising clock edge. An edge request shows after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 32 | Interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq_out | output | 1 | Registered interrupt line to the processor |

## Verification
The bench targets equal-level ties, where a design that picks the higher index or lets the last compare win reports the wrong vector. It also targets a level equal to the mask, which an off-by-one threshold would let through. Sticky edge bits are checked after the input falls back, and after a clear write with bit 8 low, which a careless decode would treat as a clear. Active-low sources, the enable gate and the 3-bit truncation of level bytes are probed as well, since swapped polarity, an ungated arbiter or full-byte storage each show up at once in the status words.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NSRC = 32;
  localparam int unsigned LVLW = 3;
  localparam int unsigned SRCW = $clog2(NSRC);
  localparam int unsigned NLVLREG = NSRC / 4;

  localparam logic [7:0] A_CTL   = 8'h00;
  localparam logic [7:0] A_MODE0 = 8'h04;
  localparam logic [7:0] A_MODE1 = 8'h08;
  localparam logic [7:0] A_LVL0  = 8'h10;
  localparam logic [7:0] A_LVLN  = 8'h2C;
  localparam logic [7:0] A_MASK  = 8'h40;
  localparam logic [7:0] A_CLR   = 8'h60;
  localparam logic [7:0] A_PEND  = 8'h80;
  localparam logic [7:0] A_CUR   = 8'hA0;

  localparam int unsigned CLR_EN_BIT = 8;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           addr,
  input  logic [31:0]          wdata,
  input  logic [NSRC-1:0]      pend,
  input  logic [31:0]          cur_stat,
  output logic [31:0]          rdata,
  output logic                 en,
  output logic [2*NSRC-1:0]    mode_o,
  output logic [LVLW*NSRC-1:0] lvl_o,
  output logic [LVLW-1:0]      mask_o,
  output logic                 clr_vld,
  output logic [SRCW-1:0]      clr_idx
);
  logic                en_q;
  logic [31:0]         mode_q [2];
  logic [LVLW-1:0]     lvl_q  [NLVLREG][4];
  logic [LVLW-1:0]     mask_q;
  logic                lvl_hit;
  logic [2:0]          lvl_sel;

  assign lvl_hit = (addr >= A_LVL0) && (addr <= A_LVLN) && (addr[1:0] == 2'b00);
  assign lvl_sel = 3'((addr - A_LVL0) >> 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      mode_q[0] <= '0;
      mode_q[1] <= '0;
      mask_q    <= '0;
      for (int r = 0; r < NLVLREG; r++)
        for (int f = 0; f < 4; f++) lvl_q[r][f] <= '0;
    end else if (wr_en) begin
      if (addr == A_CTL)   en_q      <= wdata[0];
      if (addr == A_MODE0) mode_q[0] <= wdata;
      if (addr == A_MODE1) mode_q[1] <= wdata;
      if (addr == A_MASK)  mask_q    <= wdata[LVLW-1:0];
      if (lvl_hit)
        for (int f = 0; f < 4; f++) lvl_q[lvl_sel][f] <= wdata[f*8 +: LVLW];
    end
  end

  assign clr_vld = wr_en && (addr == A_CLR) && wdata[CLR_EN_BIT];
  assign clr_idx = wdata[SRCW-1:0];
  assign en      = en_q;
  assign mask_o  = mask_q;

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    localparam int R = (n % 16) / 2;
    localparam int F = (n / 16) * 2 + (n & 1);
    assign lvl_o[n*LVLW +: LVLW] = lvl_q[R][F];
    assign mode_o[2*n +: 2]      = mode_q[n/16][(n%16)*2 +: 2];
  end

  always_comb begin
    rdata = '0;
    if (lvl_hit) begin
      for (int f = 0; f < 4; f++) rdata[f*8 +: LVLW] = lvl_q[lvl_sel][f];
    end else begin
      case (addr)
        A_CTL:   rdata = {31'b0, en_q};
        A_MODE0: rdata = mode_q[0];
        A_MODE1: rdata = mode_q[1];
        A_MASK:  rdata = {{(32-LVLW){1'b0}}, mask_q};
        A_PEND:  rdata = pend;
        A_CUR:   rdata = cur_stat;
        default: rdata = '0;
      endcase
    end
  end

  // R5: a mask write is held from the next cycle on
  p_mask_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MASK) |=> (mask_q == $past(wdata[LVLW-1:0])));
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_in,
  input  logic [2*NSRC-1:0] mode,
  input  logic              clr_vld,
  input  logic [SRCW-1:0]   clr_idx,
  output logic [NSRC-1:0]   pend
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] sticky_q;
  logic [NSRC-1:0] sticky_d;
  logic [NSRC-1:0] set_v;

  for (genvar n = 0; n < NSRC; n++) begin : g_det
    logic is_edge, pol, rise, fall, drop;
    assign is_edge     = mode[2*n+1];
    assign pol         = mode[2*n];
    assign rise        = req_in[n] & ~prev_q[n];
    assign fall        = ~req_in[n] & prev_q[n];
    assign set_v[n]    = is_edge & (pol ? rise : fall);
    assign drop        = ~is_edge | (clr_vld && clr_idx == SRCW'(n));
    assign sticky_d[n] = set_v[n] | (sticky_q[n] & ~drop);
    assign pend[n]     = sticky_q[n] | (~is_edge & (req_in[n] == pol));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      sticky_q <= '0;
    end else begin
      prev_q   <= req_in;
      sticky_q <= sticky_d;
    end
  end

  // R7: a clear with no fresh edge on that source empties its sticky bit
  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && !set_v[clr_idx]) |=> !sticky_q[$past(clr_idx)]);
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
(
  input  logic                 en,
  input  logic [NSRC-1:0]      pend,
  input  logic [LVLW*NSRC-1:0] lvl,
  input  logic [LVLW-1:0]      mask,
  output logic                 found,
  output logic [SRCW-1:0]      win_idx,
  output logic [LVLW-1:0]      win_lvl
);
  logic [LVLW-1:0] best;

  // ascending scan with strict compare: ties stay with the lower number
  always_comb begin
    found   = 1'b0;
    best    = mask;
    win_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (en && pend[i] && (lvl[i*LVLW +: LVLW] > best)) begin
        found   = 1'b1;
        best    = lvl[i*LVLW +: LVLW];
        win_idx = SRCW'(i);
      end
    end
    win_lvl = found ? best : '0;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] req_in,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_out
);
  logic                 en;
  logic [2*NSRC-1:0]    mode;
  logic [LVLW*NSRC-1:0] lvl;
  logic [LVLW-1:0]      mask;
  logic                 clr_vld;
  logic [SRCW-1:0]      clr_idx;
  logic [NSRC-1:0]      pend;
  logic                 found;
  logic [SRCW-1:0]      win_idx;
  logic [LVLW-1:0]      win_lvl;
  logic [31:0]          cs_d, cs_q;
  logic                 irq_q;

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pend(pend), .cur_stat(cs_q), .rdata(rdata), .en(en), .mode_o(mode),
    .lvl_o(lvl), .mask_o(mask), .clr_vld(clr_vld), .clr_idx(clr_idx)
  );

  irqc_detect u_det (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .mode(mode),
    .clr_vld(clr_vld), .clr_idx(clr_idx), .pend(pend)
  );

  irqc_arb u_arb (
    .en(en), .pend(pend), .lvl(lvl), .mask(mask),
    .found(found), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  always_comb begin
    cs_d        = '0;
    cs_d[16]    = ~found;
    cs_d[10:8]  = win_lvl;
    cs_d[4:0]   = win_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 32'h0001_0000;
      irq_q <= 1'b0;
    end else begin
      cs_q  <= cs_d;
      irq_q <= found;
    end
  end

  assign irq_out = irq_q;

  // R2: a disabled controller drops the line on the next cycle
  p_irq_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq_out);

  // R5: any winner is pending and sits above the mask
  p_win_above_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (win_lvl > mask && pend[win_idx]));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_in = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_ctrl u0 (.*);

  // {req, mask, expected current-status}
  localparam logic [66:0] VEC [13] = '{
    {32'h0000_0000, 3'd0, 32'h0001_0000},
    {32'h0000_0002, 3'd0, 32'h0000_0201},
    {32'h0000_0088, 3'd0, 32'h0000_0503},
    {32'h0000_008A, 3'd0, 32'h0000_0503},
    {32'h0010_0008, 3'd0, 32'h0000_0614},
    {32'h4010_0000, 3'd0, 32'h0000_071E},
    {32'h0000_008A, 3'd5, 32'h0001_0000},
    {32'h0000_008A, 3'd4, 32'h0000_0503},
    {32'h0000_0020, 3'd0, 32'h0001_0000},
    {32'h4012_0082, 3'd7, 32'h0001_0000},
    {32'h4012_0082, 3'd6, 32'h0000_071E},
    {32'h0002_0002, 3'd1, 32'h0000_0411},
    {32'hFFFF_FFFF, 3'd0, 32'h0000_071E}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic drive(input logic [31:0] r);
    @(negedge clk);
    req_in = r;
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic cur_chk(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    rd(8'hA0, v);
    chk(tag, v, exp);
    chk({tag, " R9 irq"}, {31'b0, irq_out}, {31'b0, ~exp[16]});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd(8'h00, v); chk("R1 enable", v, 32'h0);
    rd(8'h04, v); chk("R1 mode0", v, 32'h0);
    rd(8'h08, v); chk("R1 mode1", v, 32'h0);
    rd(8'h10, v); chk("R1 level", v, 32'h0);
    rd(8'h40, v); chk("R1 mask", v, 32'h0);
    cur_chk("R1 status", 32'h0001_0000);

    // setup: all high-level mode (R3), levels per R4 map
    wr(8'h04, 32'h5555_5555);
    wr(8'h08, 32'h5555_5555);
    wr(8'h10, 32'h0400_0200); // s1=2, s17=4
    wr(8'h14, 32'h0000_0500); // s3=5
    wr(8'h18, 32'h0006_0000); // s20=6
    wr(8'h1C, 32'h0000_0500); // s7=5
    wr(8'h2C, 32'h0007_0000); // s30=7
    wr(8'h00, 32'h1);

    // R5 R6 R8 R9 R11: vector walk
    for (int i = 0; i < 13; i++) begin
      wr(8'h40, {29'b0, VEC[i][34:32]});
      drive(VEC[i][66:35]);
      cur_chk($sformatf("R6 vec%0d", i), VEC[i][31:0]);
    end
    rd(8'h80, v); chk("R10 pending all-high", v, 32'hFFFF_FFFF);

    // R7: rising edge on s3, falling edge on s7
    wr(8'h40, 32'h0);
    drive(32'h0);
    wr(8'h04, 32'h5555_95D5);
    drive(32'h0000_0008);
    cur_chk("R7 rise seen", 32'h0000_0503);
    drive(32'h0);
    cur_chk("R7 sticky", 32'h0000_0503);
    rd(8'h80, v); chk("R10 sticky bit", v, 32'h0000_0008);
    wr(8'h60, 32'h0000_0003);
    drive(32'h0);
    cur_chk("R7 clear without bit8 ignored", 32'h0000_0503);
    wr(8'h60, 32'h0000_0103);
    drive(32'h0);
    cur_chk("R7 cleared", 32'h0001_0000);
    rd(8'h80, v); chk("R10 after clear", v, 32'h0);
    drive(32'h0000_0080);
    cur_chk("R7 no fall yet", 32'h0001_0000);
    drive(32'h0);
    cur_chk("R7 fall seen", 32'h0000_0507);
    wr(8'h60, 32'h0000_0107);
    drive(32'h0);
    cur_chk("R7 fall cleared", 32'h0001_0000);

    // R3: active-low sources 16..31
    wr(8'h08, 32'h0);
    drive(32'h0);
    cur_chk("R3 low active", 32'h0000_071E);
    drive(32'h4010_0000);
    cur_chk("R3 low released", 32'h0000_0411);

    // R2: enable gate
    wr(8'h00, 32'h0);
    drive(32'h4010_0000);
    cur_chk("R2 disabled", 32'h0001_0000);

    // R4: only 3 bits per level byte
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R4 truncation", v, 32'h0707_0707);

    summary();
  end
endmodule